// File: doc/BRIEF.md
# Delegating Interrupt Pending Selector

This block keeps a hart's vector of pending local interrupts and picks the one to take next. It also keeps a vector of interrupt lines that outside sources have reserved. Each cycle it qualifies the pending bits against an enable mask. It then splits them by a delegation mask. Bits that are not delegated are taken only when the machine-level gate is open. Delegated bits are taken only when the supervisor-level gate is open. The lowest-numbered bit that survives is the one reported, through a registered valid flag and index.

The pending vector changes only through a masked read-modify-write port. Bits under the mask take the new value and all other bits keep their old value. The block returns the previous vector one cycle after the write. The claim port accepts a set of lines to reserve. The claim is refused if any requested line is already reserved, and accepted otherwise. The block raises a hard-interrupt request whenever the pending vector is non-zero.

Both request ports are single-beat valid/response streams and never apply back-pressure. A request presented with its valid high on a rising edge is always accepted. Its response valid is high for exactly the following cycle. Privilege level, gate enables and masks are plain level inputs.

Top module: `irqsel_top`

## Requirements
- R1: After reset the pending and reserved vectors are zero, and `sel_valid`, `sel_num`, `irq_req`, `upd_rsp_valid` and `clm_rsp_valid` are all 0.
- R2: An update accepted on an edge sets the pending vector to (old AND NOT `upd_mask`) OR (`upd_value` AND `upd_mask`). In the next cycle, `upd_rsp_valid` is 1 and `upd_old` shows the vector as it was before that edge.
- R3: `irq_req` is 1 exactly when the pending vector, as left by the latest update, is non-zero.
- R4: A pending bit i is a candidate only when `enable_mask[i]` is 1. A candidate with `deleg_mask[i]` = 0 qualifies only when the machine gate is open. The machine gate is open when the effective privilege is below machine, or when it is machine and `glb_m_ie` is 1.
- R5: A candidate with `deleg_mask[i]` = 1 qualifies only when the supervisor gate is open. The supervisor gate is open when the effective privilege is user, or when it is supervisor and `glb_s_ie` is 1. In machine mode, delegated bits are therefore never selected.
- R6: When any bit qualifies, `sel_valid` is 1 and `sel_num` is the lowest qualifying index.
- R7: When no bit qualifies, `sel_valid` is 0 and `sel_num` is 0.
- R8: `sel_valid` and `sel_num` are registered. They reflect the inputs and pending vector held during the previous cycle, so a pending update shows up in the selection two edges after it is presented.
- R9: A claim whose `clm_bits` overlap the reserved vector returns `clm_ok` = 0 and leaves the reserved vector unchanged. Otherwise it ORs `clm_bits` into the reserved vector and returns `clm_ok` = 1. In both cases `clm_rsp_valid` is 1 in the next cycle.
- R10: `priv_lvl` encodes 0 as user, 1 as supervisor and 3 as machine. The value 2 is treated as user.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_lvl | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine, 2 treated as user) |
| glb_m_ie | input | 1 | Global machine interrupt enable |
| glb_s_ie | input | 1 | Global supervisor interrupt enable |
| enable_mask | input | NUM_IRQ | Per-line interrupt enable |
| deleg_mask | input | NUM_IRQ | Per-line delegation to supervisor |
| upd_valid | input | 1 | Pending-vector update request |
| upd_mask | input | NUM_IRQ | Bits to be written |
| upd_value | input | NUM_IRQ | New values for masked bits |
| upd_rsp_valid | output | 1 | Update response valid |
| upd_old | output | NUM_IRQ | Pending vector before the update |
| clm_valid | input | 1 | Claim request |
| clm_bits | input | NUM_IRQ | Lines to reserve |
| clm_rsp_valid | output | 1 | Claim response valid |
| clm_ok | output | 1 | Claim accepted |
| irq_req | output | 1 | Hard-interrupt request, pending vector non-zero |
| sel_valid | output | 1 | An interrupt is selected |
| sel_num | output | IDX_W | Index of the selected interrupt |

## Verification
The bound checker checks the following on every cycle:
- every request gets its response one cycle later, and the returned old value matches the vector before the write;
- a refused claim leaves the reserved vector untouched;
- a reported index points at a bit that was pending and enabled in the previous cycle;
- no delegated line is reported while in machine mode;
- the index is zero whenever nothing is selected.

Only the bench scenarios show the following:
- the lowest-index choice among several qualifying bits;
- how the two gates interact across privilege levels, including the reserved privilege encoding;
- partial-mask writes;
- the two-edge latency of a new pending bit reaching the selection.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  typedef enum logic [1:0] {
    PRV_USER  = 2'd0,
    PRV_SUPER = 2'd1,
    PRV_RSVD  = 2'd2,
    PRV_MACH  = 2'd3
  } priv_e;

  function automatic priv_e effective_priv(input logic [1:0] raw);
    priv_e p;
    p = priv_e'(raw);
    if (p == PRV_RSVD) p = PRV_USER;
    return p;
  endfunction
endpackage

// File: rtl/irqsel_pending.sv
module irqsel_pending #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_valid,
  input  logic [NUM_IRQ-1:0] upd_mask,
  input  logic [NUM_IRQ-1:0] upd_value,
  output logic               upd_rsp_valid,
  output logic [NUM_IRQ-1:0] upd_old,
  output logic [NUM_IRQ-1:0] pend_vec
);
  logic [NUM_IRQ-1:0] pend_next;

  always_comb begin
    pend_next = (pend_vec & ~upd_mask) | (upd_value & upd_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vec      <= '0;
      upd_old       <= '0;
      upd_rsp_valid <= 1'b0;
    end else begin
      upd_rsp_valid <= upd_valid;
      if (upd_valid) begin
        upd_old  <= pend_vec;
        pend_vec <= pend_next;
      end
    end
  end
endmodule

// File: rtl/irqsel_claim.sv
module irqsel_claim #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clm_valid,
  input  logic [NUM_IRQ-1:0] clm_bits,
  output logic               clm_rsp_valid,
  output logic               clm_ok,
  output logic [NUM_IRQ-1:0] claim_vec
);
  logic overlap;

  always_comb begin
    overlap = |(claim_vec & clm_bits);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      claim_vec     <= '0;
      clm_ok        <= 1'b0;
      clm_rsp_valid <= 1'b0;
    end else begin
      clm_rsp_valid <= clm_valid;
      if (clm_valid) begin
        clm_ok <= !overlap;
        if (!overlap) claim_vec <= claim_vec | clm_bits;
      end
    end
  end
endmodule

// File: rtl/irqsel_gate.sv
module irqsel_gate
  import irqsel_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic [1:0]         priv_lvl,
  input  logic               glb_m_ie,
  input  logic               glb_s_ie,
  input  logic [NUM_IRQ-1:0] pend_vec,
  input  logic [NUM_IRQ-1:0] enable_mask,
  input  logic [NUM_IRQ-1:0] deleg_mask,
  output logic [NUM_IRQ-1:0] qual_vec
);
  priv_e eff;
  logic  m_open;
  logic  s_open;
  logic [NUM_IRQ-1:0] cand;

  always_comb begin
    eff    = effective_priv(priv_lvl);
    m_open = (eff != PRV_MACH) || glb_m_ie;
    s_open = (eff == PRV_USER) || ((eff == PRV_SUPER) && glb_s_ie);
    cand   = pend_vec & enable_mask;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign qual_vec[i] = cand[i] & (deleg_mask[i] ? s_open : m_open);
  end
endmodule

// File: rtl/irqsel_pick.sv
module irqsel_pick #(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] qual_vec,
  output logic               sel_valid,
  output logic [IDX_W-1:0]   sel_num
);
  logic [IDX_W-1:0] low_idx;
  logic             any_q;

  always_comb begin
    low_idx = '0;
    any_q   = |qual_vec;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (qual_vec[i]) low_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_valid <= 1'b0;
      sel_num   <= '0;
    end else begin
      sel_valid <= any_q;
      sel_num   <= any_q ? low_idx : '0;
    end
  end
endmodule

// File: rtl/irqsel_top.sv
module irqsel_top #(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         priv_lvl,
  input  logic               glb_m_ie,
  input  logic               glb_s_ie,
  input  logic [NUM_IRQ-1:0] enable_mask,
  input  logic [NUM_IRQ-1:0] deleg_mask,
  input  logic               upd_valid,
  input  logic [NUM_IRQ-1:0] upd_mask,
  input  logic [NUM_IRQ-1:0] upd_value,
  output logic               upd_rsp_valid,
  output logic [NUM_IRQ-1:0] upd_old,
  input  logic               clm_valid,
  input  logic [NUM_IRQ-1:0] clm_bits,
  output logic               clm_rsp_valid,
  output logic               clm_ok,
  output logic               irq_req,
  output logic               sel_valid,
  output logic [IDX_W-1:0]   sel_num
);
  logic [NUM_IRQ-1:0] pend_vec;
  logic [NUM_IRQ-1:0] claim_vec;
  logic [NUM_IRQ-1:0] qual_vec;

  irqsel_pending #(.NUM_IRQ(NUM_IRQ)) u_pending (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_mask(upd_mask), .upd_value(upd_value),
    .upd_rsp_valid(upd_rsp_valid), .upd_old(upd_old), .pend_vec(pend_vec)
  );

  irqsel_claim #(.NUM_IRQ(NUM_IRQ)) u_claim (
    .clk(clk), .rst_n(rst_n),
    .clm_valid(clm_valid), .clm_bits(clm_bits),
    .clm_rsp_valid(clm_rsp_valid), .clm_ok(clm_ok), .claim_vec(claim_vec)
  );

  irqsel_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
    .priv_lvl(priv_lvl), .glb_m_ie(glb_m_ie), .glb_s_ie(glb_s_ie),
    .pend_vec(pend_vec), .enable_mask(enable_mask), .deleg_mask(deleg_mask),
    .qual_vec(qual_vec)
  );

  irqsel_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
    .clk(clk), .rst_n(rst_n), .qual_vec(qual_vec),
    .sel_valid(sel_valid), .sel_num(sel_num)
  );

  assign irq_req = |pend_vec;
endmodule

// File: rtl/irqsel_checker.sv
module irqsel_checker #(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         priv_lvl,
  input logic [NUM_IRQ-1:0] enable_mask,
  input logic [NUM_IRQ-1:0] deleg_mask,
  input logic               upd_valid,
  input logic               upd_rsp_valid,
  input logic [NUM_IRQ-1:0] upd_old,
  input logic               clm_valid,
  input logic [NUM_IRQ-1:0] clm_bits,
  input logic               clm_rsp_valid,
  input logic               clm_ok,
  input logic               sel_valid,
  input logic [IDX_W-1:0]   sel_num,
  input logic [NUM_IRQ-1:0] pend_vec,
  input logic [NUM_IRQ-1:0] claim_vec
);
  assert_upd_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (upd_rsp_valid && (upd_old == $past(pend_vec))));

  assert_claim_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clm_valid && ((claim_vec & clm_bits) != '0)) |=>
      (clm_rsp_valid && !clm_ok && (claim_vec == $past(claim_vec))));

  assert_sel_is_candidate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> ((($past(pend_vec & enable_mask) >> sel_num) & 1) != 0));

  assert_mach_no_deleg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && ($past(priv_lvl) == 2'd3)) |->
      ((($past(deleg_mask) >> sel_num) & 1) == 0));

  assert_none_idx_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (sel_num == '0));

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sel_valid && !upd_rsp_valid && !clm_rsp_valid));
endmodule

bind irqsel_top irqsel_checker #(.NUM_IRQ(NUM_IRQ)) u_irqsel_chk (
  .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl),
  .enable_mask(enable_mask), .deleg_mask(deleg_mask),
  .upd_valid(upd_valid), .upd_rsp_valid(upd_rsp_valid), .upd_old(upd_old),
  .clm_valid(clm_valid), .clm_bits(clm_bits),
  .clm_rsp_valid(clm_rsp_valid), .clm_ok(clm_ok),
  .sel_valid(sel_valid), .sel_num(sel_num),
  .pend_vec(pend_vec), .claim_vec(claim_vec)
);

// File: tb/test_irqsel_top.sv
module test_irqsel_top;
  localparam int N = 32;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   priv_lvl = 2'd3;
  logic         glb_m_ie = 1'b0, glb_s_ie = 1'b0;
  logic [N-1:0] enable_mask = '0, deleg_mask = '0;
  logic         upd_valid = 1'b0;
  logic [N-1:0] upd_mask = '0, upd_value = '0;
  logic         upd_rsp_valid;
  logic [N-1:0] upd_old;
  logic         clm_valid = 1'b0;
  logic [N-1:0] clm_bits = '0;
  logic         clm_rsp_valid, clm_ok, irq_req, sel_valid;
  logic [W-1:0] sel_num;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] mdl_pend  = '0;
  logic [N-1:0] mdl_claim = '0;
  logic [N-1:0] q_upd[$];
  logic         q_clm[$];

  always #4 clk = ~clk;

  irqsel_top #(.NUM_IRQ(N)) i_irqsel_top (.*);

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as responses appear
  always @(negedge clk) begin
    if (rst_n && upd_rsp_valid) begin
      if (q_upd.size() == 0) check("R2 unexpected update response", 1, 0);
      else check("R2 old value", upd_old, q_upd.pop_front());
    end
    if (rst_n && clm_rsp_valid) begin
      if (q_clm.size() == 0) check("R9 unexpected claim response", 1, 0);
      else check("R9 claim result", N'(clm_ok), N'(q_clm.pop_front()));
    end
  end

  task automatic do_upd(input logic [N-1:0] m, input logic [N-1:0] v);
    @(negedge clk);
    upd_valid = 1'b1; upd_mask = m; upd_value = v;
    q_upd.push_back(mdl_pend);
    mdl_pend = (mdl_pend & ~m) | (v & m);
    @(negedge clk);
    upd_valid = 1'b0;
    check("R3 irq_req", N'(irq_req), N'(mdl_pend != 0));
  endtask

  task automatic do_clm(input logic [N-1:0] b);
    @(negedge clk);
    clm_valid = 1'b1; clm_bits = b;
    if ((mdl_claim & b) != 0) q_clm.push_back(1'b0);
    else begin q_clm.push_back(1'b1); mdl_claim = mdl_claim | b; end
    @(negedge clk);
    clm_valid = 1'b0;
  endtask

  function automatic int model_sel(input logic [1:0] p, input logic mie, input logic sie,
                                   input logic [N-1:0] en, input logic [N-1:0] dl);
    logic [1:0] e;
    logic mo, so;
    logic [N-1:0] q;
    e  = (p == 2'd2) ? 2'd0 : p;
    mo = (e != 2'd3) || mie;
    so = (e == 2'd0) || ((e == 2'd1) && sie);
    q  = (mdl_pend & en & ~dl & {N{mo}}) | (mdl_pend & en & dl & {N{so}});
    for (int i = 0; i < N; i++) if (q[i]) return i;
    return -1;
  endfunction

  task automatic check_sel(input string req, input logic [1:0] p, input logic mie, input logic sie,
                           input logic [N-1:0] en, input logic [N-1:0] dl);
    int exp;
    @(negedge clk);
    priv_lvl = p; glb_m_ie = mie; glb_s_ie = sie; enable_mask = en; deleg_mask = dl;
    exp = model_sel(p, mie, sie, en, dl);
    @(negedge clk);
    check({req, " sel_valid"}, N'(sel_valid), N'(exp >= 0));
    check({req, " sel_num"}, N'(sel_num), (exp >= 0) ? N'(exp) : '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sel_valid", N'(sel_valid), 0);
    check("R1 irq_req", N'(irq_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sel_num", N'(sel_num), 0);
    check("R1 rsp valids", N'({upd_rsp_valid, clm_rsp_valid}), 0);

    do_upd('1, 32'h0000_0A00);                                   // R2 R3
    check_sel("R4 R6 machine open", 2'd3, 1, 0, '1, '0);          // expect 9
    check_sel("R4 R7 machine closed", 2'd3, 0, 1, '1, '0);        // none
    check_sel("R5 deleg blocked in M", 2'd3, 1, 1, '1, 32'h200);  // expect 11
    check_sel("R5 supervisor open", 2'd1, 0, 1, '1, 32'h200);     // expect 9
    check_sel("R5 supervisor closed", 2'd1, 0, 0, '1, 32'h200);   // expect 11
    check_sel("R10 priv 2 as user", 2'd2, 0, 0, '1, '1);          // expect 9
    check_sel("R4 enable clear", 2'd3, 1, 0, ~32'h200, '0);       // expect 11
    check_sel("R7 all delegated in M", 2'd3, 1, 1, '1, '1);       // none

    do_upd(32'h0000_0F00, 32'h0000_0100);                         // R2 partial
    check_sel("R6 partial update", 2'd0, 0, 0, '1, '0);           // expect 8
    do_upd('1, 32'h8000_0000);
    check_sel("R6 top line", 2'd3, 1, 0, '1, '0);                 // expect 31
    do_upd('1, '0);
    check_sel("R7 R3 empty", 2'd3, 1, 0, '1, '0);

    // R8: new pending bit appears two edges after presentation
    @(negedge clk);
    upd_valid = 1'b1; upd_mask = '1; upd_value = 32'h1;
    q_upd.push_back(mdl_pend); mdl_pend = 32'h1;
    @(negedge clk);
    upd_valid = 1'b0;
    check("R8 not yet selected", N'(sel_valid), 0);
    @(negedge clk);
    check("R8 selected", N'(sel_valid), 1);
    check("R8 index", N'(sel_num), 0);

    do_clm(32'h3); do_clm(32'h4); do_clm(32'h6);
    do_clm(32'h8); do_clm(32'h4); do_clm(32'h8000_0000);          // R9
    repeat (2) @(negedge clk);
    check("R9 R2 scoreboard drained", N'(q_upd.size() + q_clm.size()), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule